// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the access address for a memory port that runs short bursts. A start address is captured on a load cycle. Each later advance cycle then moves the two least significant address bits to the next beat of a four-beat burst. The bits above them stay exactly as they were loaded. The controller drives one advance/load line: low starts a new burst and high steps the current one. An active-low clock enable can freeze the block for any number of cycles without losing its place in the burst.

Two beat orders are available through a strap input. Linear order adds the beat index to the start offset, modulo four. Interleaved order XORs the beat index into the start offset. In both orders the burst returns to its start offset after the fourth beat. Stepping needs no qualification other than the clock enable. A burst keeps sequencing whether or not the surrounding device is selected, and whether the access is a read or a write.

Top module: `burst_addr_seq`

## Requirements
- R1: With rst_n low at a rising clock edge, addr_out becomes 0 and the beat index becomes 0, so a following advance in linear order gives addr_out = 1.
- R2: At an edge with clk_en_n = 0 and adv_ld = 0, addr_out takes the value of load_addr after that edge.
- R3: With order_sel = 0 (linear), beat n of a burst has addr_out[1:0] = (start + n) mod 4, where start is load_addr[1:0] at the load; each advance raises the low bits by one modulo 4.
- R4: With order_sel = 1 (interleaved), beat n of a burst has addr_out[1:0] = start XOR n.
- R5: After four advances the low bits return to the start offset, and the sequence then repeats.
- R6: At an edge with clk_en_n = 1, addr_out and the beat index are unchanged whatever adv_ld and load_addr are; the next advance continues from the beat that was held.
- R7: An advance never changes addr_out[ADDR_W-1:2]; wrapping from offset 3 to 0 carries nothing into bit 2.
- R8: A load during a burst restarts the beat index at zero from the new start address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock qualifier, active low; high freezes all state |
| adv_ld | input | 1 | 1 = advance to the next beat, 0 = load a new start address |
| load_addr | input | ADDR_W | Start address captured on a load |
| order_sel | input | 1 | Static strap: 1 = interleaved order, 0 = linear order; tie high when unused |
| addr_out | output | ADDR_W | Current access address |

## Verification
The assertions check on every cycle that a load copies the address, that a frozen cycle leaves the address still, that an advance never touches the upper bits, and that a linear advance raises the low bits by exactly one. The exact interleaved beat values, the wrap back to the start after four beats, the restart of the beat index on a mid-burst load, and the reset state depend on a whole sequence of cycles. Only the bench's scenarios can show those behaviours.

// File: rtl/burst_pkg.sv
// Shared types and beat arithmetic for the burst address sequencer.
// Assumes a four-beat burst, so the sequenced field is two bits wide.
package burst_pkg;

    localparam int LOW_W = 2;

    typedef logic [LOW_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // Linear order: start offset plus beat index, modulo the burst length.
    function automatic beat_t linear_beat(beat_t start, beat_t idx);
        return beat_t'(start + idx);
    endfunction

    // Interleaved order: beat index XORed into the start offset.
    function automatic beat_t interleave_beat(beat_t start, beat_t idx);
        return start ^ idx;
    endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
// Beat index counter. It clears on a load and steps by one on an advance.
// It wraps naturally at four and holds when neither strobe is set.
// Assumes the caller never raises load and step together.
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  logic  step_i,
    output beat_t beat_o
);

    beat_t beat_q;

    // Keep the beat index: clear on reset or load, increment on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (load_i) begin
            beat_q <= '0;
        end else if (step_i) begin
            beat_q <= beat_t'(beat_q + 1'b1);
        end
    end

    assign beat_o = beat_q;

endmodule

// File: rtl/burst_base_reg.sv
// Start-address register. It captures the whole address on a load and
// otherwise keeps it. It splits the value into the upper bits, which pass
// to the output, and the start offset that seeds the beat order.
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int HI_W  = ADDR_W - LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [HI_W-1:0]   hi_o,
    output beat_t             start_o
);

    logic [HI_W-1:0] hi_q;
    beat_t           start_q;

    // Capture the start address on a load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            start_q <= '0;
        end else if (load_i) begin
            hi_q    <= addr_i[ADDR_W-1:LOW_W];
            start_q <= addr_i[LOW_W-1:0];
        end
    end

    assign hi_o    = hi_q;
    assign start_o = start_q;

endmodule

// File: rtl/burst_order_map.sv
// Maps start offset and beat index to the current low address bits.
// Purely combinational. ORDER_FIXED picks a variant: 0 muxes both orders
// under the strap, 1 builds linear only, 2 builds interleaved only.
module burst_order_map
    import burst_pkg::*;
#(
    parameter int ORDER_FIXED = 0
) (
    input  burst_order_e order_i,
    input  beat_t        start_i,
    input  beat_t        beat_i,
    output beat_t        low_o
);

    generate
        if (ORDER_FIXED == 1) begin : g_lin_only
            // Linear order only; the strap is not used.
            always_comb low_o = linear_beat(start_i, beat_i);
        end else if (ORDER_FIXED == 2) begin : g_ilv_only
            // Interleaved order only; the strap is not used.
            always_comb low_o = interleave_beat(start_i, beat_i);
        end else begin : g_strap
            // Select the beat order from the strap.
            always_comb begin
                if (order_i == ORD_INTERLEAVE) begin
                    low_o = interleave_beat(start_i, beat_i);
                end else begin
                    low_o = linear_beat(start_i, beat_i);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer top. It decodes clock enable and advance/load
// into load and step strobes, keeps the start address and the beat index,
// and builds the output from the loaded upper bits and the sequenced low
// bits. Assumes order_sel is static while a burst runs.
module burst_addr_seq
    import burst_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int ORDER_FIXED = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              adv_ld,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int HI_W = ADDR_W - LOW_W;

    logic            qual;
    logic            do_load;
    logic            do_step;
    logic [HI_W-1:0] hi_bits;
    beat_t           start_off;
    beat_t           beat_idx;
    beat_t           low_bits;
    burst_order_e    order;

    // Turn the clock qualifier and advance/load into one-hot strobes.
    always_comb begin
        qual    = !clk_en_n;
        do_load = qual && !adv_ld;
        do_step = qual && adv_ld;
        order   = burst_order_e'(order_sel);
    end

    burst_base_reg #(
        .ADDR_W (ADDR_W)
    ) i_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (do_load),
        .addr_i  (load_addr),
        .hi_o    (hi_bits),
        .start_o (start_off)
    );

    burst_beat_ctr i_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (do_load),
        .step_i (do_step),
        .beat_o (beat_idx)
    );

    burst_order_map #(
        .ORDER_FIXED (ORDER_FIXED)
    ) i_map (
        .order_i (order),
        .start_i (start_off),
        .beat_i  (beat_idx),
        .low_o   (low_bits)
    );

    // Join the loaded upper bits with the sequenced low bits.
    always_comb addr_out = {hi_bits, low_bits};

endmodule

// File: rtl/burst_addr_seq_chk.sv
// Cycle-level checker for the burst address sequencer, bound to the top.
// Assumes order_sel is static except at loads.
module burst_addr_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              adv_ld,
    input logic [ADDR_W-1:0] load_addr,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_out
);

    // R2: a qualified load copies the whole address.
    a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld) |=> (addr_out == $past(load_addr)));

    // R6: a frozen edge leaves the address where it was.
    a_r6_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(addr_out) || !$stable(order_sel)));

    // R7: an advance never disturbs the upper bits.
    a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld) |=> (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));

    // R3: a linear advance raises the low bits by exactly one, modulo four.
    a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld && !order_sel) |=>
            (order_sel || (addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1))));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) i_burst_addr_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .adv_ld    (adv_ld),
    .load_addr (load_addr),
    .order_sel (order_sel),
    .addr_out  (addr_out)
);

// File: tb/test_burst_addr_seq.sv
// Bench for the burst address sequencer: a vector table walked by one loop,
// then directed reset and corner-case tests.
module test_burst_addr_seq;

    localparam int  ADDR_W     = 16;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NV         = 20;

    typedef struct packed {
        logic              cen_n;
        logic              adv;
        logic              ilv;
        logic [ADDR_W-1:0] ld;
        logic [ADDR_W-1:0] exp;
        logic [3:0]        req;
    } vec_t;

    // Each row: clock enable, advance/load, strap, load address, expected
    // address after the edge, requirement number for the message.
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 16'h1232, 16'h1232, 4'd2},  // R2 load linear
        '{1'b0, 1'b1, 1'b0, 16'h0000, 16'h1233, 4'd3},  // R3 beat 1
        '{1'b0, 1'b1, 1'b0, 16'h0000, 16'h1230, 4'd7},  // R7 wrap, no carry
        '{1'b0, 1'b1, 1'b0, 16'h0000, 16'h1231, 4'd3},  // R3 beat 3
        '{1'b0, 1'b1, 1'b0, 16'h0000, 16'h1232, 4'd5},  // R5 back to start
        '{1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h1232, 4'd6},  // R6 frozen advance
        '{1'b1, 1'b0, 1'b0, 16'hABCD, 16'h1232, 4'd6},  // R6 frozen load
        '{1'b0, 1'b1, 1'b0, 16'h0000, 16'h1233, 4'd6},  // R6 continues beat 1
        '{1'b0, 1'b0, 1'b1, 16'hBEE1, 16'hBEE1, 4'd2},  // R2 load interleaved
        '{1'b0, 1'b1, 1'b1, 16'h0000, 16'hBEE0, 4'd4},  // R4 1^1
        '{1'b0, 1'b1, 1'b1, 16'h0000, 16'hBEE3, 4'd4},  // R4 1^2
        '{1'b0, 1'b1, 1'b1, 16'h0000, 16'hBEE2, 4'd4},  // R4 1^3
        '{1'b0, 1'b1, 1'b1, 16'h0000, 16'hBEE1, 4'd5},  // R5 interleaved wrap
        '{1'b0, 1'b1, 1'b1, 16'h0000, 16'hBEE0, 4'd5},  // R5 repeats
        '{1'b0, 1'b0, 1'b1, 16'h7FFE, 16'h7FFE, 4'd8},  // R8 mid-burst load
        '{1'b0, 1'b1, 1'b1, 16'h0000, 16'h7FFF, 4'd8},  // R8 beat 1: 2^1
        '{1'b0, 1'b1, 1'b1, 16'h0000, 16'h7FFC, 4'd4},  // R4 2^2
        '{1'b0, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 4'd2},  // R2 load all ones
        '{1'b0, 1'b1, 1'b0, 16'h0000, 16'hFFFC, 4'd7},  // R7 no carry at top
        '{1'b0, 1'b1, 1'b0, 16'h0000, 16'hFFFD, 4'd3}   // R3 beat 2
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              clk_en_n;
    logic              adv_ld;
    logic [ADDR_W-1:0] load_addr;
    logic              order_sel;
    logic [ADDR_W-1:0] addr_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en_n  (clk_en_n),
        .adv_ld    (adv_ld),
        .load_addr (load_addr),
        .order_sel (order_sel),
        .addr_out  (addr_out)
    );

    task automatic check(input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp,
                         input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: addr_out=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then sample at the next falling edge.
    task automatic cycle(input logic cen, input logic adv, input logic ilv,
                         input logic [ADDR_W-1:0] ld);
        clk_en_n  = cen;
        adv_ld    = adv;
        order_sel = ilv;
        load_addr = ld;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n     = 1'b0;
        clk_en_n  = 1'b1;
        adv_ld    = 1'b1;
        load_addr = '0;
        order_sel = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset state is zero.
        check(addr_out, 16'h0000, "R1 reset value");
        rst_n = 1'b1;
        // R1: beat index starts at zero, so a linear advance gives offset 1.
        cycle(1'b0, 1'b1, 1'b0, 16'h0000);
        check(addr_out, 16'h0001, "R1 beat index after reset");

        for (int i = 0; i < NV; i++) begin
            cycle(VECS[i].cen_n, VECS[i].adv, VECS[i].ilv, VECS[i].ld);
            check(addr_out, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R3: linear start at offset 3 walks 3,0,1,2.
        cycle(1'b0, 1'b0, 1'b0, 16'h4443);
        cycle(1'b0, 1'b1, 1'b0, 16'h0000);
        check(addr_out, 16'h4440, "R3 linear from 3 beat 1");
        cycle(1'b0, 1'b1, 1'b0, 16'h0000);
        check(addr_out, 16'h4441, "R3 linear from 3 beat 2");

        // R4: interleaved start at offset 3 walks 3,2,1,0.
        cycle(1'b0, 1'b0, 1'b1, 16'h5553);
        cycle(1'b0, 1'b1, 1'b1, 16'h0000);
        check(addr_out, 16'h5552, "R4 interleaved from 3 beat 1");
        cycle(1'b0, 1'b1, 1'b1, 16'h0000);
        check(addr_out, 16'h5551, "R4 interleaved from 3 beat 2");
        cycle(1'b0, 1'b1, 1'b1, 16'h0000);
        check(addr_out, 16'h5550, "R4 interleaved from 3 beat 3");

        // R1: reset in the middle of a burst clears address and beat index.
        rst_n = 1'b0;
        cycle(1'b0, 1'b1, 1'b1, 16'h0000);
        check(addr_out, 16'h0000, "R1 reset mid-burst");
        rst_n = 1'b1;
        cycle(1'b0, 1'b1, 1'b1, 16'h0000);
        check(addr_out, 16'h0001, "R1 beat index cleared by reset");

        // R6: long freeze with toggling controls keeps the beat.
        for (int k = 0; k < 5; k++) begin
            cycle(1'b1, k[0], 1'b1, 16'h9999);
        end
        check(addr_out, 16'h0001, "R6 long freeze");
        cycle(1'b0, 1'b1, 1'b1, 16'h0000);
        check(addr_out, 16'h0002, "R6 resume after freeze (0^2)");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule